// File: doc/BRIEF.md
# Machine-Check Error Bank Logger

This block keeps a row of machine-check reporting banks for one processor core. Each bank holds four 64-bit words: an enable mask, a status word, the faulting address and a free-form detail word. Two more words apply to every bank: a global enable mask and a global status word. A read-only capability word gives the number of banks and says whether the global enable mask is in use.

Error sources present one injection at a time. An injection names a bank and carries a status word, a global-status word, an address and a detail word. The block handles the injection in the cycle it is presented. It then does one of five things: it discards the injection, logs it, sets the overflow flag on the entry already in the bank, raises a one-cycle machine-check exception pulse, or raises a one-cycle system-reset request pulse. Uncorrected and corrected errors are treated differently. A corrected error never replaces an uncorrected entry that is still pending. A second uncorrected error that arrives while the first is still in progress escalates to a reset request. Software reads and writes every word through a simple register port, which is how it clears the in-progress flag and the bank entries.

Top module: `mcb_logger`

## Requirements
- R1: After reset, the global enable mask and every bank enable mask read all ones, and every status, address and detail word reads zero, global status included. The capability word at address 0 holds the bank count in bits 7:0 and the global-mask-in-use flag in bit 8, with zeros elsewhere.
- R2: Register map: address 0 is the capability word, 1 is global status and 2 is the global enable mask. Bank b occupies addresses 4+4b to 7+4b, holding its enable mask, status, address and detail words in that order. `reg_rdata` shows the addressed word combinationally. A write updates the addressed word at the next clock edge. Writes to the capability word have no effect, and a write is ignored in any cycle where `inj_valid` is high.
- R3: An injection whose bank index is not below the bank count, or whose status lacks the valid bit (bit 63), changes no word and raises no pulse.
- R4: A status word with bit 61 set marks an uncorrected error. When the global mask is in use and the global enable mask is not all ones, an uncorrected error is discarded with no pulse.
- R5: An uncorrected error aimed at a bank whose enable mask is not all ones is discarded with no pulse. The bank mask has no effect on corrected errors.
- R6: If an uncorrected error is not discarded and either the in-progress flag (global status bit 2) is set or `mce_en` is low, the block pulses `reset_req` and leaves every bank unchanged.
- R7: Otherwise an uncorrected error writes its status, address and detail into the bank, copies the injected global-status word into global status, and pulses `mce_irq`.
- R8: When an uncorrected error is logged into a bank whose status already had bit 63 set, the stored status also has the overflow bit (bit 62) set.
- R9: A corrected error aimed at a bank that is empty or holds a corrected entry writes the status, address and detail words. Overflow is set if the bank held a valid entry. Global status is unchanged and no pulse is raised.
- R10: A corrected error aimed at a bank that holds a valid uncorrected entry only sets bit 62 of that entry. Its other status bits, its address and its detail word are kept.
- R11: `busy` stays low. `mce_irq` and `reset_req` each rise in the cycle after the deciding injection, last exactly one cycle, and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inj_valid | input | 1 | Injection present this cycle |
| inj_bank | input | 8 | Target bank index |
| inj_status | input | 64 | Error status word |
| inj_gstatus | input | 64 | Global status word to copy on an uncorrected log |
| inj_addr | input | 64 | Faulting address |
| inj_misc | input | 64 | Detail word |
| mce_en | input | 1 | Machine-check exceptions enabled by the core's control register |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_addr` |
| busy | output | 1 | Always low; injections are taken every cycle |
| mce_irq | output | 1 | One-cycle machine-check exception request |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The hardest situations to reach are the nested uncorrected error and a corrected error landing on a pending uncorrected entry. Both depend on state left behind by an earlier injection, not on the current inputs. The stimulus first logs an uncorrected error whose injected global-status word carries the in-progress bit. It then sends a second uncorrected error to the same bank to force the reset path. Next it clears global status through the register port and sends a corrected error to that bank, so the only visible effect should be the overflow bit. It also checks that an uncorrected error blocked by a cleared bank mask is discarded before the in-progress test can request a reset.

// File: rtl/mcb_pkg.sv
package mcb_pkg;

  localparam int unsigned WORD_W   = 64;
  localparam int unsigned VAL_BIT  = 63;
  localparam int unsigned OVF_BIT  = 62;
  localparam int unsigned UC_BIT   = 61;
  localparam int unsigned MCIP_BIT = 2;
  localparam int unsigned BANK_BASE = 4;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    ACT_NONE     = 3'd0,
    ACT_LOG_UC   = 3'd1,
    ACT_LOG_CE   = 3'd2,
    ACT_MARK_OVF = 3'd3,
    ACT_RESET    = 3'd4
  } act_e;

  typedef enum logic [1:0] {
    FLD_CTL    = 2'd0,
    FLD_STATUS = 2'd1,
    FLD_ADDR   = 2'd2,
    FLD_MISC   = 2'd3
  } field_e;

  function automatic logic is_valid(input word_t w);
    return w[VAL_BIT];
  endfunction

  function automatic logic is_uc(input word_t w);
    return w[UC_BIT];
  endfunction

  function automatic logic all_ones(input word_t w);
    return &w;
  endfunction

  function automatic word_t with_ovf(input word_t w, input logic set);
    word_t r;
    r = w;
    if (set) r[OVF_BIT] = 1'b1;
    return r;
  endfunction

  function automatic word_t make_cap(input int unsigned nb, input logic has_gctl);
    word_t r;
    r = '0;
    r[7:0] = 8'(nb);
    r[8] = has_gctl;
    return r;
  endfunction

endpackage

// File: rtl/mcb_bank.sv
module mcb_bank
  import mcb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_field,
  input  logic [63:0] wr_data,
  input  logic        log_en,
  input  logic [63:0] log_status,
  input  logic [63:0] log_addr,
  input  logic [63:0] log_misc,
  input  logic        ovf_en,
  output logic [63:0] ctl_q,
  output logic [63:0] status_q,
  output logic [63:0] addr_q,
  output logic [63:0] misc_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q    <= '1;
      status_q <= '0;
      addr_q   <= '0;
      misc_q   <= '0;
    end else if (wr_en) begin
      case (field_e'(wr_field))
        FLD_CTL:    ctl_q    <= wr_data;
        FLD_STATUS: status_q <= wr_data;
        FLD_ADDR:   addr_q   <= wr_data;
        default:    misc_q   <= wr_data;
      endcase
    end else if (log_en) begin
      status_q <= log_status;
      addr_q   <= log_addr;
      misc_q   <= log_misc;
    end else if (ovf_en) begin
      status_q[OVF_BIT] <= 1'b1;
    end
  end

  // R5: only a register write may change the enable mask
  a_r5_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctl_q));

  // R10: overflow marking lands in the status word
  a_r10_ovf_marked: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_en && !wr_en && !log_en) |=> status_q[OVF_BIT]);

  // R10: a pending uncorrected entry is never replaced by a corrected one
  a_r10_uc_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[VAL_BIT] && status_q[UC_BIT] && !wr_en && !(log_en && log_status[UC_BIT]))
      |=> status_q[UC_BIT]);

  a_r9_log_ovf_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(log_en && ovf_en));

endmodule

// File: rtl/mcb_decide.sv
module mcb_decide
  import mcb_pkg::*;
#(
  parameter bit HAS_GLOBAL_CTL = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inj_valid,
  input  logic        bank_in_range,
  input  logic [63:0] inj_status,
  input  logic        mce_en,
  input  logic [63:0] gctl,
  input  logic [63:0] gstatus,
  input  logic [63:0] sel_ctl,
  input  logic [63:0] sel_status,
  output act_e        act,
  output logic [63:0] log_word
);

  logic accept, uc_req, uc_blocked, uc_nested, bank_holds_uc;

  assign accept        = inj_valid && bank_in_range && is_valid(inj_status);
  assign uc_req        = is_uc(inj_status);
  assign uc_blocked    = (HAS_GLOBAL_CTL && !all_ones(gctl)) || !all_ones(sel_ctl);
  assign uc_nested     = gstatus[MCIP_BIT] || !mce_en;
  assign bank_holds_uc = is_valid(sel_status) && is_uc(sel_status);

  always_comb begin
    act      = ACT_NONE;
    log_word = with_ovf(inj_status, is_valid(sel_status));
    if (accept) begin
      if (uc_req) begin
        if (uc_blocked)     act = ACT_NONE;
        else if (uc_nested) act = ACT_RESET;
        else                act = ACT_LOG_UC;
      end else if (bank_holds_uc) begin
        act = ACT_MARK_OVF;
      end else begin
        act = ACT_LOG_CE;
      end
    end
  end

  // R3: no action without a valid, in-range request
  a_r3_no_action_when_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |-> act == ACT_NONE);

  // R4: blocked uncorrected requests take no action
  a_r4_blocked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && uc_req && uc_blocked) |-> act == ACT_NONE);

endmodule

// File: rtl/mcb_logger.sv
module mcb_logger
  import mcb_pkg::*;
#(
  parameter int unsigned NUM_BANKS      = 10,
  parameter int unsigned ADDR_W         = 8,
  parameter bit          HAS_GLOBAL_CTL = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inj_valid,
  input  logic [7:0]  inj_bank,
  input  logic [63:0] inj_status,
  input  logic [63:0] inj_gstatus,
  input  logic [63:0] inj_addr,
  input  logic [63:0] inj_misc,
  input  logic        mce_en,
  input  logic        reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [63:0] reg_wdata,
  output logic [63:0] reg_rdata,
  output logic        busy,
  output logic        mce_irq,
  output logic        reset_req
);

  localparam int unsigned BANK_AW = ADDR_W - 2;
  localparam word_t CAP_WORD = make_cap(NUM_BANKS, HAS_GLOBAL_CTL);

  logic [63:0] bank_ctl    [NUM_BANKS];
  logic [63:0] bank_status [NUM_BANKS];
  logic [63:0] bank_addr   [NUM_BANKS];
  logic [63:0] bank_misc   [NUM_BANKS];

  logic [63:0] gstatus_q, gctl_q;
  logic        irq_q, rst_q;

  // injection target selection
  logic        bank_in_range;
  logic [63:0] sel_ctl, sel_status;

  assign bank_in_range = 32'(inj_bank) < NUM_BANKS;

  always_comb begin
    sel_ctl    = '0;
    sel_status = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (32'(inj_bank) == b) begin
        sel_ctl    = bank_ctl[b];
        sel_status = bank_status[b];
      end
    end
  end

  act_e        act;
  logic [63:0] log_word;

  mcb_decide #(.HAS_GLOBAL_CTL(HAS_GLOBAL_CTL)) u_decide (
    .clk           (clk),
    .rst_n         (rst_n),
    .inj_valid     (inj_valid),
    .bank_in_range (bank_in_range),
    .inj_status    (inj_status),
    .mce_en        (mce_en),
    .gctl          (gctl_q),
    .gstatus       (gstatus_q),
    .sel_ctl       (sel_ctl),
    .sel_status    (sel_status),
    .act           (act),
    .log_word      (log_word)
  );

  // register decode
  logic               wr_ok, addr_global;
  logic [ADDR_W-1:0]  bank_off;
  logic [BANK_AW-1:0] r_bank;
  logic [1:0]         r_field;

  assign wr_ok       = reg_wr && !inj_valid;
  assign addr_global = reg_addr < ADDR_W'(BANK_BASE);
  assign bank_off    = reg_addr - ADDR_W'(BANK_BASE);
  assign r_bank      = bank_off[ADDR_W-1:2];
  assign r_field     = bank_off[1:0];

  logic do_log, do_ovf;
  assign do_log = (act == ACT_LOG_UC) || (act == ACT_LOG_CE);
  assign do_ovf = (act == ACT_MARK_OVF);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic hit_inj, hit_reg;
    assign hit_inj = (32'(inj_bank) == g);
    assign hit_reg = !addr_global && (32'(r_bank) == g);

    mcb_bank u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_ok && hit_reg),
      .wr_field   (r_field),
      .wr_data    (reg_wdata),
      .log_en     (do_log && hit_inj),
      .log_status (log_word),
      .log_addr   (inj_addr),
      .log_misc   (inj_misc),
      .ovf_en     (do_ovf && hit_inj),
      .ctl_q      (bank_ctl[g]),
      .status_q   (bank_status[g]),
      .addr_q     (bank_addr[g]),
      .misc_q     (bank_misc[g])
    );
  end

  // global words and output pulses
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gstatus_q <= '0;
      gctl_q    <= '1;
      irq_q     <= 1'b0;
      rst_q     <= 1'b0;
    end else begin
      irq_q <= (act == ACT_LOG_UC);
      rst_q <= (act == ACT_RESET);
      if (act == ACT_LOG_UC) begin
        gstatus_q <= inj_gstatus;
      end else if (wr_ok && addr_global) begin
        if (reg_addr == ADDR_W'(1)) gstatus_q <= reg_wdata;
        if (reg_addr == ADDR_W'(2)) gctl_q    <= reg_wdata;
      end
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (addr_global) begin
      case (reg_addr[1:0])
        2'd0:    reg_rdata = CAP_WORD;
        2'd1:    reg_rdata = gstatus_q;
        2'd2:    reg_rdata = gctl_q;
        default: reg_rdata = '0;
      endcase
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (32'(r_bank) == b) begin
          case (field_e'(r_field))
            FLD_CTL:    reg_rdata = bank_ctl[b];
            FLD_STATUS: reg_rdata = bank_status[b];
            FLD_ADDR:   reg_rdata = bank_addr[b];
            default:    reg_rdata = bank_misc[b];
          endcase
        end
      end
    end
  end

  assign busy      = 1'b0;
  assign mce_irq   = irq_q;
  assign reset_req = rst_q;

  a_r11_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy);

  a_r11_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mce_irq && reset_req));

  a_r3_out_of_range_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid && !bank_in_range) |=> (!mce_irq && !reset_req));

  a_r3_invalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid && !inj_status[VAL_BIT]) |=> (!mce_irq && !reset_req));

  a_r6_nested_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid && bank_in_range && inj_status[VAL_BIT] && inj_status[UC_BIT] &&
     (&gctl_q) && (&sel_ctl) && gstatus_q[MCIP_BIT]) |=> reset_req);

  a_r7_gstatus_copied: assert property (@(posedge clk) disable iff (!rst_n)
    mce_irq |-> (gstatus_q == $past(inj_gstatus)));

endmodule

// File: tb/tb_mcb_logger.sv
module tb_mcb_logger;

  localparam logic [63:0] V  = 64'h8000_0000_0000_0000;
  localparam logic [63:0] O  = 64'h4000_0000_0000_0000;
  localparam logic [63:0] U  = 64'h2000_0000_0000_0000;
  localparam logic [63:0] ONES = '1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inj_valid = 1'b0;
  logic [7:0]  inj_bank = '0;
  logic [63:0] inj_status = '0, inj_gstatus = '0, inj_addr = '0, inj_misc = '0;
  logic        mce_en = 1'b1;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        busy, mce_irq, reset_req;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mcb_logger dut (
    .clk(clk), .rst_n(rst_n), .inj_valid(inj_valid), .inj_bank(inj_bank),
    .inj_status(inj_status), .inj_gstatus(inj_gstatus), .inj_addr(inj_addr),
    .inj_misc(inj_misc), .mce_en(mce_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .mce_irq(mce_irq), .reset_req(reset_req)
  );

  function automatic logic [7:0] ba(input int b, input int f);
    return 8'(4 + 4 * b + f);
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [63:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // one injection; pulses are sampled in the cycle after, then must drop
  task automatic inject(input string tag, input int b, input logic [63:0] st,
                        input logic [63:0] gs, input logic [63:0] ad,
                        input logic [63:0] mi, input logic exp_irq, input logic exp_rst);
    @(negedge clk);
    inj_valid = 1'b1; inj_bank = 8'(b); inj_status = st;
    inj_gstatus = gs; inj_addr = ad; inj_misc = mi;
    check({tag, " R11 busy"}, 64'(busy), 64'd0);
    @(negedge clk);
    inj_valid = 1'b0;
    check({tag, " irq"}, 64'(mce_irq), 64'(exp_irq));
    check({tag, " reset_req"}, 64'(reset_req), 64'(exp_rst));
    @(negedge clk);
    check({tag, " R11 pulse end"}, 64'(mce_irq | reset_req), 64'd0);
  endtask

  task automatic t_reset_state;
    rd("R1 capability", 8'd0, 64'h10A);
    rd("R1 global ctl", 8'd2, ONES);
    rd("R1 global status", 8'd1, 64'd0);
    rd("R1 bank0 ctl", ba(0, 0), ONES);
    rd("R1 bank9 ctl", ba(9, 0), ONES);
    rd("R1 bank3 status", ba(3, 1), 64'd0);
  endtask

  task automatic t_regport;
    wr(ba(2, 2), 64'h1234);
    rd("R2 bank2 addr readback", ba(2, 2), 64'h1234);
    wr(8'd0, 64'hFFFF);
    rd("R2 capability read-only", 8'd0, 64'h10A);
  endtask

  task automatic t_ignore;
    inject("R3 out of range", 10, V | U, 64'h4, 64'h1, 64'h1, 1'b0, 1'b0);
    rd("R3 bank9 untouched", ba(9, 1), 64'd0);
    inject("R3 no valid bit", 1, U | 64'h7, 64'h4, 64'h1, 64'h1, 1'b0, 1'b0);
    rd("R3 bank1 untouched", ba(1, 1), 64'd0);
    rd("R3 global status untouched", 8'd1, 64'd0);
  endtask

  task automatic t_corrected;
    inject("R9 ce empty", 1, V | 64'hAA, 64'h9, 64'hA1, 64'hB1, 1'b0, 1'b0);
    rd("R9 status", ba(1, 1), V | 64'hAA);
    rd("R9 addr", ba(1, 2), 64'hA1);
    rd("R9 misc", ba(1, 3), 64'hB1);
    rd("R9 gstatus unchanged", 8'd1, 64'd0);
    inject("R9 ce over ce", 1, V | 64'hBB, 64'h0, 64'hA2, 64'hB2, 1'b0, 1'b0);
    rd("R9 status overflow", ba(1, 1), V | O | 64'hBB);
    rd("R9 addr replaced", ba(1, 2), 64'hA2);
  endtask

  task automatic t_uncorrected;
    inject("R7 uc log", 3, V | U | 64'h11, 64'h5, 64'h3000, 64'h31, 1'b1, 1'b0);
    rd("R7 status", ba(3, 1), V | U | 64'h11);
    rd("R7 addr", ba(3, 2), 64'h3000);
    rd("R7 misc", ba(3, 3), 64'h31);
    rd("R7 gstatus copied", 8'd1, 64'h5);
    inject("R6 nested uc", 3, V | U | 64'h22, 64'h0, 64'h3100, 64'h32, 1'b0, 1'b1);
    rd("R6 bank3 kept", ba(3, 1), V | U | 64'h11);
    rd("R6 gstatus kept", 8'd1, 64'h5);
    wr(8'd1, 64'd0);
    inject("R10 ce over uc", 3, V | 64'h33, 64'h0, 64'h3200, 64'h33, 1'b0, 1'b0);
    rd("R10 status only ovf", ba(3, 1), V | O | U | 64'h11);
    rd("R10 addr kept", ba(3, 2), 64'h3000);
    rd("R10 misc kept", ba(3, 3), 64'h31);
    inject("R8 uc over valid", 3, V | U | 64'h44, 64'h4, 64'h3300, 64'h34, 1'b1, 1'b0);
    rd("R8 status with ovf", ba(3, 1), V | O | U | 64'h44);
    rd("R8 addr", ba(3, 2), 64'h3300);
  endtask

  task automatic t_mce_disabled;
    wr(8'd1, 64'd0);
    mce_en = 1'b0;
    inject("R6 mce off", 4, V | U | 64'h1, 64'h4, 64'h40, 64'h41, 1'b0, 1'b1);
    rd("R6 bank4 empty", ba(4, 1), 64'd0);
    mce_en = 1'b1;
    wr(8'd1, 64'h4);
  endtask

  task automatic t_bank_mask;
    wr(ba(5, 0), 64'd0);
    inject("R5 bank mask drops uc", 5, V | U | 64'h5, 64'h0, 64'h50, 64'h51, 1'b0, 1'b0);
    rd("R5 bank5 empty", ba(5, 1), 64'd0);
    inject("R5 bank mask keeps ce", 5, V | 64'h55, 64'h0, 64'h52, 64'h53, 1'b0, 1'b0);
    rd("R5 ce logged", ba(5, 1), V | 64'h55);
  endtask

  task automatic t_global_mask;
    wr(8'd2, ~64'd1);
    inject("R4 global mask drops uc", 6, V | U | 64'h6, 64'h0, 64'h60, 64'h61, 1'b0, 1'b0);
    rd("R4 bank6 empty", ba(6, 1), 64'd0);
    wr(8'd2, ONES);
    rd("R2 global ctl restored", 8'd2, ONES);
  endtask

  task automatic t_write_collision;
    @(negedge clk);
    inj_valid = 1'b1; inj_bank = 8'd8; inj_status = V | 64'h88;
    inj_addr = 64'h80; inj_misc = 64'h81; inj_gstatus = '0;
    reg_wr = 1'b1; reg_addr = ba(7, 2); reg_wdata = 64'h77;
    @(negedge clk);
    inj_valid = 1'b0; reg_wr = 1'b0;
    rd("R2 write during injection ignored", ba(7, 2), 64'd0);
    rd("R9 bank8 logged", ba(8, 1), V | 64'h88);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state;
    t_regport;
    t_ignore;
    t_corrected;
    t_uncorrected;
    t_mce_disabled;
    t_bank_mask;
    t_global_mask;
    t_write_collision;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule